// File: doc/BRIEF.md
# Float to Signed Integer Truncating Converter

This block turns an already unpacked floating-point operand into a signed two's complement integer. The operand arrives as a class code, a sign, a signed unbiased exponent, a normalised mantissa whose low bits act as guard and round bits, and a separate sticky bit. The conversion always chops toward zero, whatever rounding mode the surrounding unit uses. It reports whether any fraction was lost (inexact) and whether the operand had no representable integer (invalid).

An operand that is too large, infinite or not-a-number saturates to the most positive or most negative integer, chosen by its sign. Invalid then takes the place of inexact. The result and both flags are registered: they appear one clock after a valid strobe and are held until the next strobe.

Top module: `fp2i_trunc`

## Requirements
- R1: Class code 0 (zero) gives result 0 with inexact and invalid both low, for either sign.
- R2: Class codes 2 (infinity) and 3 (not-a-number) set invalid, clear inexact, and return 0x7FFFFFFF for sign 0 or 0x80000000 for sign 1.
- R3: Class code 1 (number) with exponent of 32 or more saturates like R2 and sets invalid.
- R4: For class 1 with exponent 0 to 31, where mantissa bit MANT_W-1 carries weight 2^exponent, the magnitude is the integer part truncated toward zero and never incremented. A negative result is its two's complement.
- R5: For a non-saturated class 1 result, inexact is high exactly when a discarded mantissa bit or the sticky input is 1.
- R6: A class 1 operand with a negative exponent, down to -32768, gives 0, and inexact is high if any mantissa bit or sticky is 1.
- R7: A magnitude of 0x80000000 is accepted only for sign 1 (result 0x80000000, invalid low). For sign 0 it saturates to 0x7FFFFFFF with invalid high. A larger magnitude saturates for either sign.
- R8: Result, flags and valid_o update on the clock edge after valid_i is high. valid_o is high for exactly that cycle, and result and flags hold their values while valid_i is low.
- R9: During reset, valid_o, result_o, inexact_o and invalid_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operand strobe |
| cls_i | input | 2 | Class: 0 zero, 1 number, 2 infinity, 3 not-a-number |
| sign_i | input | 1 | Operand sign, 1 = negative |
| exp_i | input | 16 | Signed unbiased exponent |
| mant_i | input | 40 | Normalised mantissa, MSB weight 2^exp |
| sticky_i | input | 1 | OR of bits already dropped below the mantissa |
| valid_o | output | 1 | Result strobe, one cycle after valid_i |
| result_o | output | 32 | Signed integer result |
| inexact_o | output | 1 | Fraction lost in truncation |
| invalid_o | output | 1 | Operand saturated: too large, infinite or not-a-number |

## Verification
The assertions assume that the operand fields are stable and known whenever valid_i is high. They also assume valid_i is low throughout reset, so that the one-cycle latency and hold properties have a defined previous cycle. The bench drives every field from a known value at reset and changes inputs only on falling clock edges. Class 1 operands always have the top mantissa bit set, except where a test targets sticky alone. Exponents cover the saturation edge at 31 and 32 and the most negative value.

// File: rtl/fp2i_pkg.sv
package fp2i_pkg;
  typedef enum logic [1:0] {
    CLS_ZERO = 2'd0,
    CLS_NUM  = 2'd1,
    CLS_INF  = 2'd2,
    CLS_NAN  = 2'd3
  } fp_cls_e;
endpackage

// File: rtl/fp2i_align.sv
// Moves the integer part of the mantissa into an INT_W window and reports lost bits.
module fp2i_align #(
  parameter int MANT_W = 40,
  parameter int EXP_W  = 16,
  parameter int INT_W  = 32
) (
  input  logic                    sign_i,
  input  logic signed [EXP_W-1:0] exp_i,
  input  logic [MANT_W-1:0]       mant_i,
  input  logic                    sticky_i,
  output logic [INT_W-1:0]        mag_o,
  output logic                    lost_o,
  output logic                    big_o
);
  localparam int SH_W   = $clog2(INT_W + 1);
  localparam int WIDE_W = INT_W + MANT_W;

  logic              in_win;
  logic [SH_W-1:0]   shamt;
  logic [WIDE_W-1:0] wide;

  assign big_o  = exp_i >= EXP_W'(INT_W);
  assign in_win = !exp_i[EXP_W-1] && !big_o;
  assign shamt  = exp_i[SH_W-1:0] + SH_W'(1);
  assign wide   = {{INT_W{1'b0}}, mant_i} << shamt;

  always_comb begin
    if (in_win) begin
      mag_o  = wide[WIDE_W-1:MANT_W];
      lost_o = (|wide[MANT_W-1:0]) | sticky_i;
    end else begin
      mag_o  = '0;
      lost_o = (|mant_i) | sticky_i;
    end
  end

  // sign is not used in alignment; kept visible for the range checker
  logic unused_sign;
  assign unused_sign = sign_i;
endmodule

// File: rtl/fp2i_sat.sv
// Range check, negation and saturation.
module fp2i_sat #(
  parameter int INT_W = 32
) (
  input  fp2i_pkg::fp_cls_e cls_i,
  input  logic              sign_i,
  input  logic [INT_W-1:0]  mag_i,
  input  logic              lost_i,
  input  logic              big_i,
  output logic [INT_W-1:0]  result_o,
  output logic              inexact_o,
  output logic              invalid_o
);
  import fp2i_pkg::*;
  localparam logic [INT_W:0]   LIM     = (INT_W+1)'(1) << (INT_W - 1);
  localparam logic [INT_W-1:0] POS_MAX = {1'b0, {(INT_W-1){1'b1}}};
  localparam logic [INT_W-1:0] NEG_MIN = {1'b1, {(INT_W-1){1'b0}}};

  logic too_wide;
  assign too_wide = {1'b0, mag_i} >= (LIM + (INT_W+1)'(sign_i));

  always_comb begin
    result_o  = '0;
    inexact_o = 1'b0;
    invalid_o = 1'b0;
    unique case (cls_i)
      CLS_ZERO: ;
      CLS_NUM: begin
        if (big_i || too_wide) begin
          invalid_o = 1'b1;
          result_o  = sign_i ? NEG_MIN : POS_MAX;
        end else begin
          inexact_o = lost_i;
          result_o  = sign_i ? (~mag_i + INT_W'(1)) : mag_i;
        end
      end
      default: begin
        invalid_o = 1'b1;
        result_o  = sign_i ? NEG_MIN : POS_MAX;
      end
    endcase
  end
endmodule

// File: rtl/fp2i_trunc.sv
module fp2i_trunc #(
  parameter int MANT_W = 40,
  parameter int EXP_W  = 16,
  parameter int INT_W  = 32
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    valid_i,
  input  logic [1:0]              cls_i,
  input  logic                    sign_i,
  input  logic signed [EXP_W-1:0] exp_i,
  input  logic [MANT_W-1:0]       mant_i,
  input  logic                    sticky_i,
  output logic                    valid_o,
  output logic [INT_W-1:0]        result_o,
  output logic                    inexact_o,
  output logic                    invalid_o
);
  import fp2i_pkg::*;
  localparam logic [INT_W-1:0] POS_MAX = {1'b0, {(INT_W-1){1'b1}}};
  localparam logic [INT_W-1:0] NEG_MIN = {1'b1, {(INT_W-1){1'b0}}};

  fp_cls_e          cls;
  logic [INT_W-1:0] mag, res_d;
  logic             lost, big, inx_d, inv_d;

  assign cls = fp_cls_e'(cls_i);

  fp2i_align #(.MANT_W(MANT_W), .EXP_W(EXP_W), .INT_W(INT_W)) u_align (
    .sign_i(sign_i), .exp_i(exp_i), .mant_i(mant_i), .sticky_i(sticky_i),
    .mag_o(mag), .lost_o(lost), .big_o(big)
  );

  fp2i_sat #(.INT_W(INT_W)) u_sat (
    .cls_i(cls), .sign_i(sign_i), .mag_i(mag), .lost_i(lost), .big_i(big),
    .result_o(res_d), .inexact_o(inx_d), .invalid_o(inv_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      result_o  <= '0;
      inexact_o <= 1'b0;
      invalid_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        result_o  <= res_d;
        inexact_o <= inx_d;
        invalid_o <= inv_d;
      end
    end
  end

  a_r1_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && cls_i == 2'd0) |=> (result_o == '0 && !inexact_o && !invalid_o));
  a_r2_special: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && cls_i[1]) |=> (invalid_o && !inexact_o));
  a_r3_big_exp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && cls_i == 2'd1 && exp_i >= EXP_W'(INT_W)) |=> invalid_o);
  a_r2_sat_value: assert property (@(posedge clk_i) disable iff (!rst_ni)
    invalid_o |-> ((result_o == POS_MAX) || (result_o == NEG_MIN)));
  a_r5_flag_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(inexact_o && invalid_o));
  a_r8_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  a_r8_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && $stable(result_o) && $stable(inexact_o)));
endmodule

// File: tb/tb_fp2i_trunc.sv
module tb_fp2i_trunc;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [1:0]  cls_i = 2'd0;
  logic        sign_i = 1'b0;
  logic signed [15:0] exp_i = '0;
  logic [39:0] mant_i = '0;
  logic        sticky_i = 1'b0;
  logic        valid_o;
  logic [31:0] result_o;
  logic        inexact_o, invalid_o;

  int n_run = 0, n_fail = 0;

  always #5 clk_i = ~clk_i;

  fp2i_trunc dut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp_v);
    n_run++;
    if (act !== exp_v) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp_v);
    end
  endtask

  // Drives one operand and checks result, flags and strobe.
  task automatic conv(string req, logic [1:0] c, logic s, int e, logic [39:0] m,
                      logic st, logic [31:0] er, logic ei, logic ev);
    @(negedge clk_i);
    cls_i = c; sign_i = s; exp_i = 16'(e); mant_i = m; sticky_i = st; valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
    chk({req, " valid"}, 32'(valid_o), 32'd1);
    chk({req, " result"}, result_o, er);
    chk({req, " inexact"}, 32'(inexact_o), 32'(ei));
    chk({req, " invalid"}, 32'(invalid_o), 32'(ev));
  endtask

  task automatic t_reset;
    chk("R9 valid", 32'(valid_o), 32'd0);
    chk("R9 result", result_o, 32'd0);
    chk("R9 flags", {30'd0, inexact_o, invalid_o}, 32'd0);
  endtask

  task automatic t_zero;
    conv("R1 +0", 2'd0, 1'b0, 5, 40'h80_0000_0000, 1'b1, 32'd0, 0, 0);
    conv("R1 -0", 2'd0, 1'b1, 0, 40'h0, 1'b0, 32'd0, 0, 0);
  endtask

  task automatic t_special;
    conv("R2 +inf", 2'd2, 1'b0, 0, 40'h0, 1'b0, 32'h7FFF_FFFF, 0, 1);
    conv("R2 -inf", 2'd2, 1'b1, 0, 40'h0, 1'b0, 32'h8000_0000, 0, 1);
    conv("R2 -nan", 2'd3, 1'b1, 3, 40'hC0_0000_0001, 1'b1, 32'h8000_0000, 0, 1);
    conv("R2 +nan", 2'd3, 1'b0, 3, 40'hC0_0000_0000, 1'b0, 32'h7FFF_FFFF, 0, 1);
  endtask

  task automatic t_big;
    conv("R3 e32 pos", 2'd1, 1'b0, 32, 40'h80_0000_0000, 1'b0, 32'h7FFF_FFFF, 0, 1);
    conv("R3 e100 neg", 2'd1, 1'b1, 100, 40'h80_0000_0001, 1'b0, 32'h8000_0000, 0, 1);
  endtask

  task automatic t_trunc;
    conv("R4 one", 2'd1, 1'b0, 0, 40'h80_0000_0000, 1'b0, 32'd1, 0, 0);
    conv("R4 11", 2'd1, 1'b0, 3, 40'hB0_0000_0000, 1'b0, 32'd11, 0, 0);
    conv("R4 -11", 2'd1, 1'b1, 3, 40'hB0_0000_0000, 1'b0, 32'hFFFF_FFF5, 0, 0);
    conv("R4 11.5 chop", 2'd1, 1'b0, 3, 40'hB8_0000_0000, 1'b0, 32'd11, 1, 0);
    conv("R4 -11.5 chop", 2'd1, 1'b1, 3, 40'hB8_0000_0000, 1'b0, 32'hFFFF_FFF5, 1, 0);
  endtask

  task automatic t_inexact;
    conv("R5 sticky only", 2'd1, 1'b0, 3, 40'hB0_0000_0000, 1'b1, 32'd11, 1, 0);
    conv("R5 e30 frac", 2'd1, 1'b0, 30, 40'hFF_FFFF_FF80, 1'b0, 32'h7FFF_FFFF, 1, 0);
    conv("R5 lsb lost", 2'd1, 1'b0, 0, 40'h80_0000_0001, 1'b0, 32'd1, 1, 0);
  endtask

  task automatic t_neg_exp;
    conv("R6 half", 2'd1, 1'b0, -1, 40'h80_0000_0000, 1'b0, 32'd0, 1, 0);
    conv("R6 -half", 2'd1, 1'b1, -1, 40'h80_0000_0000, 1'b0, 32'd0, 1, 0);
    conv("R6 min exp", 2'd1, 1'b0, -32768, 40'h80_0000_0000, 1'b0, 32'd0, 1, 0);
    conv("R6 empty", 2'd1, 1'b0, -4, 40'h0, 1'b0, 32'd0, 0, 0);
  endtask

  task automatic t_edge;
    conv("R7 +2^31", 2'd1, 1'b0, 31, 40'h80_0000_0000, 1'b0, 32'h7FFF_FFFF, 0, 1);
    conv("R7 -2^31", 2'd1, 1'b1, 31, 40'h80_0000_0000, 1'b0, 32'h8000_0000, 0, 0);
    conv("R7 -2^31 frac", 2'd1, 1'b1, 31, 40'h80_0000_0001, 1'b0, 32'h8000_0000, 1, 0);
    conv("R7 -over", 2'd1, 1'b1, 31, 40'h80_0000_0100, 1'b0, 32'h8000_0000, 0, 1);
    conv("R7 +max", 2'd1, 1'b0, 30, 40'hFF_FFFF_FE00, 1'b0, 32'h7FFF_FFFF, 0, 0);
  endtask

  task automatic t_hold;
    conv("R8 load", 2'd1, 1'b0, 3, 40'hB8_0000_0000, 1'b0, 32'd11, 1, 0);
    cls_i = 2'd2; sign_i = 1'b1;
    @(negedge clk_i);
    chk("R8 strobe drop", 32'(valid_o), 32'd0);
    chk("R8 hold result", result_o, 32'd11);
    chk("R8 hold flags", {30'd0, inexact_o, invalid_o}, 32'd2);
  endtask

  initial begin
    fork
      begin
        #1000000;
        n_run++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
      end
    join_none
    #23;
    t_reset();
    rst_ni = 1'b1;
    t_zero();
    t_special();
    t_big();
    t_trunc();
    t_inexact();
    t_neg_exp();
    t_edge();
    t_hold();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule